// File: doc/BRIEF.md
# I2C Master with Internal-Address Phase

This block is a single-master controller for the two-wire I2C bus. It reaches a register or a memory location inside a slave that uses a 7-bit address. One command carries the device address, a read/write flag, a sub-address size of zero to three bytes, a 24-bit sub-address value and one data byte. The block then runs the whole bus transaction and reports the outcome.

For a write, the sub-address bytes follow the device address, and the data byte follows them. For a read with a sub-address, the block first loads the sub-address in a write phase. It then issues a repeated START, resends the device address with the read bit set, and receives one byte. It answers that byte with NACK and closes with STOP. If a slave fails to acknowledge any byte the master sent, the block stops the transaction and raises an error flag. The error flag stays high until the next command is accepted.

Both bus lines are modelled as open-drain pads: an output enable pulls the line low, and the line level is read back as an input. SCL runs from a programmable divider of the system clock. Each SCL period lasts four quarter-phases, and each quarter-phase is `div_q+1` system clocks.

Top module: `i2c_iaddr_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl_oe` and `sda_oe` are both 0 (lines released), and `done` and `nack_err` are 0 until a transaction ends.
- R2: A write command (`cmd_read`=0) produces this bus sequence: START, then the byte {cmd_dev, 0}, then the sub-address bytes, then `cmd_wdata`, then STOP. Every byte is sent most-significant bit first, and each is followed by a slave acknowledge slot.
- R3: The number of sub-address bytes equals `cmd_asize` (0 to 3). They are sent high byte first: bits 23:16 when the size is 3, then bits 15:8 when the size is 2 or more, then bits 7:0 when the size is 1 or more. A size of 0 sends no sub-address byte.
- R4: A read command with `cmd_asize`>0 runs the write phase {cmd_dev,0} plus the sub-address bytes. It then issues a repeated START and the byte {cmd_dev,1}, receives one byte MSB first, and presents that byte on `rdata` when `done` pulses.
- R5: A read command with `cmd_asize`=0 sends START, then {cmd_dev,1}, receives one byte and then sends STOP, with no write phase.
- R6: In the acknowledge slot of the received byte the master leaves SDA released (NACK). It then sends STOP.
- R7: If SDA is sampled high in the acknowledge slot of any byte the master sent, the master sends no further byte. It sends STOP and sets `nack_err`, which stays high until the next command is accepted and is cleared then.
- R8: During byte transfer, SDA (`sda_oe`) changes only while SCL is low. It changes while SCL is high only to form START, repeated START or STOP.
- R9: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle until STOP completes. At that point `done` pulses for one cycle while `busy` is low. A command presented while busy is ignored.
- R10: One SCL period during byte transfer lasts 4*(`div_q`+1) system clock cycles, and SCL changes only on quarter-phase ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | 7-bit device address |
| cmd_asize | input | 2 | Sub-address size in bytes (0 to 3) |
| cmd_iaddr | input | 24 | Sub-address value |
| cmd_wdata | input | 8 | Byte to write |
| div_q | input | DIV_W | Quarter-phase length minus one, in clocks |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when STOP completes |
| nack_err | output | 1 | Missing acknowledge seen in last transaction |
| rdata | output | 8 | Received byte |

## Verification
The assertions check several rules on every cycle:
- the lines are released while idle;
- SDA is steady while SCL is high inside a byte;
- SCL moves only on divider ticks;
- the master NACKs the received byte;
- `done` is never raised together with `busy`;
- the error flag holds until a new command arrives;
- a command arriving during a transaction leaves the latched command untouched.

Only the bench scenarios can show the order and content of the bus traffic, as decoded by a slave model. That covers the repeated START placement, the high-byte-first sub-address trimmed to the configured size, and the abort point after a refused byte. They also show the received value and the measured SCL period.

// File: rtl/i2c_iaddr_master.sv
module i2c_iaddr_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [6:0]       cmd_dev,
  input  logic [1:0]       cmd_asize,
  input  logic [23:0]      cmd_iaddr,
  input  logic [7:0]       cmd_wdata,
  input  logic [DIV_W-1:0] div_q,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic [7:0]       rdata
);

  localparam int BITS_PER_BYTE = 8;
  localparam logic [3:0] ACK_SLOT = 4'(BITS_PER_BYTE);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} state_t;
  typedef enum logic [2:0] {G_DEVW, G_IA, G_WD, G_DEVR, G_RD} stage_t;
  typedef enum logic [1:0] {K_BYTE, K_RESTART, K_STOP} kind_t;

  state_t           state;
  stage_t           stage, nx_stage;
  kind_t            nx_kind;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       ph;
  logic [3:0]       bitc;
  logic [7:0]       sh;
  logic             restart;
  logic [1:0]       ia_left, nx_ia;
  logic             rd_q;
  logic [6:0]       dev_q;
  logic [23:0]      ia_q;
  logic [7:0]       wd_q;
  logic             sda_q;
  logic             ack_hi;
  logic             busy_q, done_q, nerr_q;
  logic [7:0]       rdata_q;

  wire accept = cmd_valid && !busy_q;
  wire tick   = busy_q && (cnt == '0);
  wire tx     = (stage != G_RD);

  assign busy     = busy_q;
  assign done     = done_q;
  assign nack_err = nerr_q;
  assign rdata    = rdata_q;
  assign sda_oe   = sda_q;
  assign scl_oe   = ((state == S_BYTE) || (state == S_STOP) ||
                     (state == S_START && restart)) && !ph[1];

  function automatic logic [7:0] byte_for(stage_t g, logic [1:0] left,
                                          logic [6:0] dv, logic [23:0] ia,
                                          logic [7:0] wd);
    case (g)
      G_DEVW:  byte_for = {dv, 1'b0};
      G_DEVR:  byte_for = {dv, 1'b1};
      G_WD:    byte_for = wd;
      G_IA:    byte_for = (left == 2'd3) ? ia[23:16] :
                          (left == 2'd2) ? ia[15:8] : ia[7:0];
      default: byte_for = 8'h00;
    endcase
  endfunction

  always_comb begin
    nx_stage = stage;
    nx_ia    = ia_left;
    nx_kind  = K_BYTE;
    case (stage)
      G_DEVW: nx_stage = (ia_left != 2'd0) ? G_IA : G_WD;
      G_IA: begin
        if (ia_left > 2'd1) begin
          nx_ia = ia_left - 2'd1;
        end else begin
          nx_ia    = 2'd0;
          nx_stage = rd_q ? G_DEVR : G_WD;
          nx_kind  = rd_q ? K_RESTART : K_BYTE;
        end
      end
      G_DEVR:  nx_stage = G_RD;
      default: nx_kind = K_STOP;
    endcase
    if (tx && ack_hi) nx_kind = K_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= div_q;
    end else if (busy_q) begin
      cnt <= (cnt == '0) ? div_q : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stage   <= G_DEVW;
      ph      <= 2'd0;
      bitc    <= 4'd0;
      sh      <= 8'h00;
      restart <= 1'b0;
      ia_left <= 2'd0;
      rd_q    <= 1'b0;
      dev_q   <= 7'd0;
      ia_q    <= 24'd0;
      wd_q    <= 8'd0;
      sda_q   <= 1'b0;
      ack_hi  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      nerr_q  <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rd_q    <= cmd_read;
        dev_q   <= cmd_dev;
        ia_q    <= cmd_iaddr;
        wd_q    <= cmd_wdata;
        ia_left <= cmd_asize;
        stage   <= (cmd_read && cmd_asize == 2'd0) ? G_DEVR : G_DEVW;
        busy_q  <= 1'b1;
        nerr_q  <= 1'b0;
        restart <= 1'b0;
        ack_hi  <= 1'b0;
        state   <= S_START;
        ph      <= 2'd0;
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (state)
          S_START: begin
            if (restart && ph == 2'd0) sda_q <= 1'b0;
            if (!restart && ph == 2'd1) sda_q <= 1'b1;
            if (restart && ph == 2'd2) sda_q <= 1'b1;
            if (ph == 2'd3) begin
              state <= S_BYTE;
              bitc  <= 4'd0;
              sh    <= byte_for(stage, ia_left, dev_q, ia_q, wd_q);
            end
          end
          S_BYTE: begin
            if (ph == 2'd0) sda_q <= tx && (bitc < ACK_SLOT) && !sh[7];
            if (ph == 2'd2) begin
              if (bitc < ACK_SLOT && !tx) sh <= {sh[6:0], sda_i};
              if (bitc == ACK_SLOT) ack_hi <= sda_i;
            end
            if (ph == 2'd3) begin
              if (bitc < ACK_SLOT) begin
                bitc <= bitc + 4'd1;
                if (tx) sh <= {sh[6:0], 1'b0};
              end else begin
                if (stage == G_RD) rdata_q <= sh;
                if (tx && ack_hi) nerr_q <= 1'b1;
                case (nx_kind)
                  K_STOP: state <= S_STOP;
                  K_RESTART: begin
                    state   <= S_START;
                    restart <= 1'b1;
                    stage   <= nx_stage;
                    ia_left <= nx_ia;
                  end
                  default: begin
                    stage   <= nx_stage;
                    ia_left <= nx_ia;
                    bitc    <= 4'd0;
                    sh      <= byte_for(nx_stage, nx_ia, dev_q, ia_q, wd_q);
                  end
                endcase
              end
            end
          end
          S_STOP: begin
            if (ph == 2'd0) sda_q <= 1'b1;
            if (ph == 2'd2) sda_q <= 1'b0;
            if (ph == 2'd3) begin
              state  <= S_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!scl_oe && !sda_oe));

  // R8
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && state == S_BYTE && $past(state) == S_BYTE)
      |-> $stable(sda_oe));

  // R10
  scl_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(scl_oe));

  // R6
  master_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BYTE && stage == G_RD && bitc == ACK_SLOT) |-> !sda_oe);

  // R7
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nerr_q && !accept) |=> nerr_q);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R9
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_valid) |=> ($stable(dev_q) && $stable(wd_q) && $stable(ia_q)));

endmodule

// File: tb/i2c_iaddr_master_bench.sv
module i2c_iaddr_master_bench;

  localparam int DIV_W = 8;
  localparam time TCLK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_dev = '0;
  logic [1:0] cmd_asize = '0;
  logic [23:0] cmd_iaddr = '0;
  logic [7:0] cmd_wdata = '0;
  logic [DIV_W-1:0] div_q = '0;
  logic scl_oe, sda_oe, busy, done, nack_err;
  logic [7:0] rdata;
  logic pull = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | pull);

  always #(TCLK/2) clk = ~clk;

  i2c_iaddr_master #(.DIV_W(DIV_W)) u_i2c_iaddr_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_dev(cmd_dev), .cmd_asize(cmd_asize), .cmd_iaddr(cmd_iaddr),
    .cmd_wdata(cmd_wdata), .div_q(div_q), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .nack_err(nack_err), .rdata(rdata));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model
  logic [8:0] ev [0:31];
  int nev = 0;
  int cnt_r = 0, bidx = 0, nack_at = -1, nrise = 0;
  logic tx_mode = 0, go_tx = 0, first_byte = 0, saw_mnack = 0;
  logic [7:0] shr = 0, sdata = 0;
  time trise [0:1];

  task automatic log_ev(input logic [8:0] v);
    if (nev < 32) ev[nev] = v;
    nev++;
  endtask

  always @(negedge sda_line) if (scl_line) begin
    log_ev(9'h100); cnt_r = 0; tx_mode = 0; go_tx = 0; first_byte = 1; pull = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    log_ev(9'h101); tx_mode = 0;
  end
  always @(posedge scl_line) begin
    if (nrise < 2) trise[nrise] = $time;
    nrise++;
    if (cnt_r < 8 && !tx_mode) shr = {shr[6:0], sda_line};
    if (cnt_r == 8 && tx_mode && sda_line) begin tx_mode = 0; saw_mnack = 1; end
    cnt_r = (cnt_r == 8) ? 0 : cnt_r + 1;
  end
  always @(negedge scl_line) begin
    if (cnt_r == 8) begin
      if (!tx_mode) begin
        log_ev({1'b0, shr});
        pull = (bidx != nack_at);
        if (first_byte && shr[0] && pull) go_tx = 1;
        bidx++; first_byte = 0;
      end else pull = 0;
    end else if (cnt_r == 0) begin
      pull = 0;
      if (go_tx) begin tx_mode = 1; go_tx = 0; end
      if (tx_mode) pull = ~sdata[7];
    end else if (tx_mode) pull = ~sdata[7-cnt_r];
  end

  // expected sequence
  logic [8:0] xp [0:31];
  int nxp, xidx;
  bit xabort;

  task automatic push_tx(input logic [7:0] b);
    if (!xabort) begin
      xp[nxp] = {1'b0, b}; nxp++;
      if (xidx == nack_at) xabort = 1;
      xidx++;
    end
  endtask

  task automatic build_exp(input bit rd, input logic [6:0] dv, input int asz,
                           input logic [23:0] ia, input logic [7:0] wd);
    nxp = 0; xidx = 0; xabort = 0;
    xp[nxp] = 9'h100; nxp++;
    if (!rd || asz > 0) begin
      push_tx({dv, 1'b0});
      for (int k = asz - 1; k >= 0; k--) push_tx(ia[8*k +: 8]);
      if (!rd) push_tx(wd);
      else if (!xabort) begin xp[nxp] = 9'h100; nxp++; push_tx({dv, 1'b1}); end
    end else push_tx({dv, 1'b1});
    xp[nxp] = 9'h101; nxp++;
  endtask

  task automatic run_cmd(input bit rd, input logic [6:0] dv, input int asz,
                         input logic [23:0] ia, input logic [7:0] wd,
                         input int dv_div, input int nk, input logic [7:0] sd,
                         input bit inject, input string tag);
    int guard;
    bit seq_ok;
    @(negedge clk);
    nev = 0; bidx = 0; nrise = 0; nack_at = nk; sdata = sd; saw_mnack = 0;
    div_q = DIV_W'(dv_div);
    cmd_read = rd; cmd_dev = dv; cmd_asize = 2'(asz); cmd_iaddr = ia; cmd_wdata = wd;
    cmd_valid = 1;
    build_exp(rd, dv, asz, ia, wd);
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    chk(nack_err == 1'b0, "R7 nack_err cleared on accept", nack_err, 0);
    if (inject) begin
      repeat (7) @(negedge clk);
      cmd_valid = 1; cmd_dev = ~dv; cmd_wdata = ~wd; cmd_iaddr = ~ia; cmd_read = ~rd;
      repeat (3) @(negedge clk);
      cmd_valid = 0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, {tag, " R9 done reached"}, done, 1);
    chk(busy == 1'b0, {tag, " R9 busy low at done"}, busy, 0);
    seq_ok = (nev == nxp);
    for (int i = 0; i < nxp && i < 32; i++) if (ev[i] != xp[i]) seq_ok = 0;
    chk(seq_ok, {tag, " R2 R3 R4 R5 R8 bus sequence"}, nev, nxp);
    if (!seq_ok) for (int i = 0; i < 32; i++)
      if (i < nev || i < nxp) $display("  ev[%0d] act=%0h exp=%0h", i, ev[i], xp[i]);
    chk(nack_err == xabort, {tag, " R7 nack_err"}, nack_err, xabort);
    if (rd && !xabort) begin
      chk(rdata == sd, {tag, asz > 0 ? " R4 rdata" : " R5 rdata"}, rdata, sd);
      chk(saw_mnack == 1'b1, {tag, " R6 master NACK"}, saw_mnack, 1);
    end
    chk(nrise >= 2 && (trise[1] - trise[0]) == time'(4 * (dv_div + 1)) * TCLK,
        {tag, " R10 SCL period"}, int'((trise[1] - trise[0]) / TCLK), 4 * (dv_div + 1));
    if (xabort) begin
      repeat (5) @(negedge clk);
      chk(nack_err == 1'b1, {tag, " R7 nack_err held"}, nack_err, 1);
    end
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe, {tag, " R1 lines released idle"}, {scl_oe, sda_oe}, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !nack_err, "R1 reset state",
        {scl_oe, sda_oe, busy, done, nack_err}, 0);
    run_cmd(0, 7'h50, 0, 24'h000000, 8'hA5, 1, -1, 8'h00, 0, "wr0");
    run_cmd(0, 7'h2C, 3, 24'h123456, 8'h3C, 2, -1, 8'h00, 0, "wr3");
    run_cmd(1, 7'h11, 0, 24'h000000, 8'h00, 0, -1, 8'hC3, 0, "rd0");
    run_cmd(1, 7'h68, 2, 24'hFFBEEF, 8'h00, 3, -1, 8'h5A, 0, "rd2");
    run_cmd(0, 7'h33, 2, 24'h00ABCD, 8'h77, 1, 0, 8'h00, 0, "nak_dev");
    run_cmd(1, 7'h44, 3, 24'hA1B2C3, 8'h00, 1, 2, 8'h99, 0, "nak_ia");
    run_cmd(1, 7'h45, 1, 24'h0000F0, 8'h00, 1, 2, 8'h99, 0, "nak_devr");
    run_cmd(0, 7'h0F, 1, 24'h000081, 8'h18, 2, -1, 8'h00, 1, "busy_ign");
    for (int t = 0; t < 30; t++) begin
      int nk;
      nk = ($urandom % 4 == 0) ? int'($urandom % 5) : -1;
      run_cmd(1'($urandom), 7'($urandom), int'($urandom % 4), 24'($urandom),
              8'($urandom), int'($urandom % 4), nk, 8'($urandom), 1'($urandom % 5 == 0), "rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule